// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port behind a small word-addressed register interface. Software writes the value each pin drives and chooses whether each pin drives or listens. It can read back the level of every pin through a two-stage synchronizer. Each pin also feeds its own interrupt detector. A 2-bit sensitivity code selects one of four detection modes for that pin.

Detected events collect in a sticky status register, which software clears by writing ones. An enable mask decides which pending bits reach the single combined interrupt line. Level sources are set again on every cycle their condition holds, so they cannot be cleared while the level persists. Edge sources stay cleared until the next qualifying transition. Detection on both edges is not built in. Software obtains it by swapping a pin between rising and falling mode after each event.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held, and after it is released, every register is zero: pin outputs, pin output enables, mask, status, both configuration words and `irqOut`.
- R2: A write to byte offset 0x00 loads the drive values, and `pinOut` shows them after that clock edge. A write to offset 0x04 loads the direction bits, and `pinOe` shows them after that edge (1 = output).
- R3: Offset 0x08 reads the synchronized pin levels. A change on `pinIn` is still hidden after one clock edge and becomes visible after the second. Offset 0x00 reads the written drive value for output pins and the synchronized level for input pins.
- R4: Pin p has a 2-bit sensitivity field at bits [2*(p mod 16)+1 : 2*(p mod 16)]. Pins 0..15 use the word at offset 0x0C and pins 16..31 the word at offset 0x10. Both words read back as written.
- R5: Code 00 (low level) and code 01 (high level) set the pin's status bit on every cycle the synchronized level matches. A clear issued while the level holds leaves the bit set.
- R6: Code 10 (rising edge) and code 11 (falling edge) set the status bit once, on a transition of the synchronized level. The bit stays set after the pin returns. After a clear it stays cleared until the next qualifying transition.
- R7: The status register at offset 0x18 is write-one-to-clear. Bits written as 0 keep their value.
- R8: A status bit is set whether or not its mask bit is set, so a source can be pending before it is enabled.
- R9: `irqOut` is high exactly when some pin has both its status bit and its mask bit (offset 0x14) set.
- R10: When a clear of a status bit and a new detection event for that bit fall on the same clock edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Byte address of the register |
| busWe | input | 1 | Write strobe, acted on at the clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| pinIn | input | 32 | Raw pin levels from the pads |
| pinOut | output | 32 | Values driven on the pins |
| pinOe | output | 32 | Output enable per pin |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench builds the port with its default parameters: 32 pins and a 5-bit address. With these values, pin 15 is the last pin in the low configuration word and pin 16 is the first pin in the high word, so the split between the two words is exercised. Pin 31, the top field of the high word, is also covered. The random rounds draw a fresh sensitivity code for every pin, so every field position in both words is checked through detection behaviour, not only through read-back.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Register byte offsets
  localparam logic [7:0] OFF_DATA   = 8'h00;
  localparam logic [7:0] OFF_DIR    = 8'h04;
  localparam logic [7:0] OFF_PAD    = 8'h08;
  localparam logic [7:0] OFF_CFGLO  = 8'h0C;
  localparam logic [7:0] OFF_CFGHI  = 8'h10;
  localparam logic [7:0] OFF_MASK   = 8'h14;
  localparam logic [7:0] OFF_STATUS = 8'h18;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_FALL = 2'b11
  } sense_e;

  typedef enum logic [2:0] {
    RD_DATA, RD_DIR, RD_PAD, RD_CFGLO, RD_CFGHI, RD_MASK, RD_STATUS, RD_NONE
  } rd_sel_e;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrCfgLo;
    logic    wrCfgHi;
    logic    wrMask;
    logic    wrStatus;
    rd_sel_e rdSel;
  } port_strobe_t;

  function automatic logic senseHit(input logic [1:0] field, input logic cur, input logic prev);
    case (sense_e'(field))
      SENSE_LOW:  senseHit = ~cur;
      SENSE_HIGH: senseHit = cur;
      SENSE_RISE: senseHit = cur & ~prev;
      default:    senseHit = prev & ~cur;
    endcase
  endfunction
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output port_strobe_t      strb
);
  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    case (busAddr)
      OFF_DATA[ADDR_W-1:0]:   begin strb.rdSel = RD_DATA;   strb.wrData   = busWe; end
      OFF_DIR[ADDR_W-1:0]:    begin strb.rdSel = RD_DIR;    strb.wrDir    = busWe; end
      OFF_PAD[ADDR_W-1:0]:    begin strb.rdSel = RD_PAD;    end
      OFF_CFGLO[ADDR_W-1:0]:  begin strb.rdSel = RD_CFGLO;  strb.wrCfgLo  = busWe; end
      OFF_CFGHI[ADDR_W-1:0]:  begin strb.rdSel = RD_CFGHI;  strb.wrCfgHi  = busWe; end
      OFF_MASK[ADDR_W-1:0]:   begin strb.rdSel = RD_MASK;   strb.wrMask   = busWe; end
      OFF_STATUS[ADDR_W-1:0]: begin strb.rdSel = RD_STATUS; strb.wrStatus = busWe; end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  port_strobe_t       strb,
  input  logic [NPINS-1:0]   busWdata,
  input  logic [NPINS-1:0]   pinIn,
  output logic [NPINS-1:0]   busRdata,
  output logic [NPINS-1:0]   pinOut,
  output logic [NPINS-1:0]   pinOe,
  output logic [NPINS-1:0]   statusQ,
  output logic [NPINS-1:0]   maskQ,
  output logic               irqOut
);
  localparam int PER_WORD = NPINS / 2;

  logic [NPINS-1:0] dataQ, dirQ, cfgLoQ, cfgHiQ;
  logic [NPINS-1:0] syncA, syncQ, prevQ;
  logic [NPINS-1:0] hit, clrBits, pinLevel;

  // Per-pin detector: field location depends on which half the pin is in
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] field;
    if (p < PER_WORD) begin : g_lo
      assign field = cfgLoQ[2*p +: 2];
    end else begin : g_hi
      assign field = cfgHiQ[2*(p-PER_WORD) +: 2];
    end
    assign hit[p] = senseHit(field, syncQ[p], prevQ[p]);
  end

  assign clrBits = strb.wrStatus ? busWdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncQ   <= '0;
      prevQ   <= '0;
      dataQ   <= '0;
      dirQ    <= '0;
      cfgLoQ  <= '0;
      cfgHiQ  <= '0;
      maskQ   <= '0;
      statusQ <= '0;
    end else begin
      syncA <= pinIn;
      syncQ <= syncA;
      prevQ <= syncQ;
      if (strb.wrData)  dataQ  <= busWdata;
      if (strb.wrDir)   dirQ   <= busWdata;
      if (strb.wrCfgLo) cfgLoQ <= busWdata;
      if (strb.wrCfgHi) cfgHiQ <= busWdata;
      if (strb.wrMask)  maskQ  <= busWdata;
      // a fresh event overrides a clear landing on the same edge
      statusQ <= (statusQ & ~clrBits) | hit;
    end
  end

  assign pinLevel = (dirQ & dataQ) | (~dirQ & syncQ);

  always_comb begin
    case (strb.rdSel)
      RD_DATA:   busRdata = pinLevel;
      RD_DIR:    busRdata = dirQ;
      RD_PAD:    busRdata = syncQ;
      RD_CFGLO:  busRdata = cfgLoQ;
      RD_CFGHI:  busRdata = cfgHiQ;
      RD_MASK:   busRdata = maskQ;
      RD_STATUS: busRdata = statusQ;
      default:   busRdata = '0;
    endcase
  end

  assign pinOut = dataQ;
  assign pinOe  = dirQ;
  assign irqOut = |(statusQ & maskQ);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [NPINS-1:0]  busWdata,
  output logic [NPINS-1:0]  busRdata,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinOe,
  output logic              irqOut
);
  port_strobe_t     strb;
  logic [NPINS-1:0] statusQ, maskQ;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strb   (strb)
  );

  gpio_irq_datapath #(.NPINS(NPINS)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busWdata(busWdata),
    .pinIn   (pinIn),
    .busRdata(busRdata),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [NPINS-1:0]  busWdata,
  input logic [NPINS-1:0]  pinOut,
  input logic [NPINS-1:0]  pinOe,
  input logic [NPINS-1:0]  statusQ,
  input logic [NPINS-1:0]  maskQ,
  input logic              irqOut
);
  logic stWrite;
  assign stWrite = busWe && (busAddr == OFF_STATUS[ADDR_W-1:0]);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (pinOe == '0 && pinOut == '0 && statusQ == '0 && !irqOut));

  assert_data_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFF_DATA[ADDR_W-1:0]) |=> (pinOut == $past(busWdata)));

  assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    !stWrite |=> (($past(statusQ) & ~statusQ) == '0));

  assert_w1c_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    stWrite |=> (($past(statusQ) & ~$past(busWdata) & ~statusQ) == '0));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & maskQ) == '0) |-> !irqOut);
endmodule

bind gpio_irq_port gpio_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWe   (busWe),
  .busWdata(busWdata),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .statusQ (statusQ),
  .maskQ   (maskQ),
  .irqOut  (irqOut)
);

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  busAddr;
  logic        busWe;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [31:0] pinIn;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irqOut;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCfg(input logic [63:0] c);
    wr(5'h0C, c[31:0]);
    wr(5'h10, c[63:32]);
  endtask

  // expected pending bits for level codes; cfg = {high word, low word}
  function automatic logic [31:0] expLevel(input logic [63:0] cfg, input logic [31:0] pins);
    for (int p = 0; p < 32; p++) begin
      case (cfg[2*p +: 2])
        2'b00:   expLevel[p] = ~pins[p];
        2'b01:   expLevel[p] = pins[p];
        default: expLevel[p] = 1'b0;
      endcase
    end
  endfunction

  function automatic logic [31:0] expEdge(input logic [63:0] cfg, input logic [31:0] oldP,
                                          input logic [31:0] newP);
    for (int p = 0; p < 32; p++) begin
      case (cfg[2*p +: 2])
        2'b10:   expEdge[p] = ~oldP[p] & newP[p];
        2'b11:   expEdge[p] = oldP[p] & ~newP[p];
        default: expEdge[p] = 1'b0;
      endcase
    end
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, d, dirV, pv, oldP, newP, st;
    logic [63:0] cfg;
    void'($urandom(32'd20240611));
    rstN = 1'b0; busAddr = '0; busWe = 1'b0; busWdata = '0; pinIn = '0;
    settle(3);
    check("R1 pinOe in reset", pinOe, 32'h0);
    check("R1 pinOut in reset", pinOut, 32'h0);
    check("R1 irqOut in reset", {31'h0, irqOut}, 32'h0);
    rstN = 1'b1;
    settle(1);
    rd(5'h04, r); check("R1 dir after reset", r, 32'h0);
    rd(5'h14, r); check("R1 mask after reset", r, 32'h0);
    rd(5'h0C, r); check("R1 cfg low after reset", r, 32'h0);
    rd(5'h10, r); check("R1 cfg high after reset", r, 32'h0);
    settle(3);
    // all pins low with code 00: all pending, none enabled
    rd(5'h18, r); check("R5 R8 low-level pending at reset defaults", r, 32'hFFFF_FFFF);
    check("R8 irq stays low with mask 0", {31'h0, irqOut}, 32'h0);

    // R2 / R3 random drive, direction and readback
    for (int i = 0; i < 8; i++) begin
      d = $urandom; dirV = $urandom; pv = $urandom;
      wr(5'h00, d);
      wr(5'h04, dirV);
      pinIn = pv;
      settle(3);
      check("R2 pinOut", pinOut, d);
      check("R2 pinOe", pinOe, dirV);
      rd(5'h00, r); check("R3 data read mix", r, (dirV & d) | (~dirV & pv));
      rd(5'h08, r); check("R3 pad read", r, pv);
    end
    // R3 synchronizer latency
    oldP = pinIn; newP = ~pinIn;
    pinIn = newP;
    settle(1);
    rd(5'h08, r); check("R3 hidden after one edge", r, oldP);
    settle(1);
    rd(5'h08, r); check("R3 visible after two edges", r, newP);
    wr(5'h04, 32'h0);

    // R4 readback of both configuration words
    d = $urandom; wr(5'h0C, d); rd(5'h0C, r); check("R4 cfg low readback", r, d);
    d = $urandom; wr(5'h10, d); rd(5'h10, r); check("R4 cfg high readback", r, d);

    // R4 / R5 random level codes: clear cannot stick
    for (int i = 0; i < 6; i++) begin
      cfg = {$urandom, $urandom} & 64'h5555_5555_5555_5555;
      pv = $urandom;
      pinIn = pv;
      setCfg(cfg);
      settle(3);
      wr(5'h18, 32'hFFFF_FFFF);
      rd(5'h18, r); check("R4 R5 level status after clear", r, expLevel(cfg, pv));
    end

    // R4 / R6 random edge codes
    for (int i = 0; i < 6; i++) begin
      cfg = {$urandom, $urandom} | 64'hAAAA_AAAA_AAAA_AAAA;
      oldP = $urandom; newP = $urandom;
      pinIn = oldP;
      setCfg(cfg);
      settle(3);
      wr(5'h18, 32'hFFFF_FFFF);
      rd(5'h18, r); check("R6 edge status stays cleared", r, 32'h0);
      pinIn = newP;
      settle(3);
      rd(5'h18, r); check("R4 R6 edge detected", r, expEdge(cfg, oldP, newP));
      pinIn = oldP;
      settle(3);
      rd(5'h18, r);
      check("R6 edge sticky after return", r, expEdge(cfg, oldP, newP) | expEdge(cfg, newP, oldP));
    end

    // directed: rising on pins 0, 16, 31
    setCfg(64'hAAAA_AAAA_AAAA_AAAA);
    pinIn = 32'h0;
    settle(3);
    wr(5'h18, 32'hFFFF_FFFF);
    pinIn = 32'h8001_0001;
    settle(3);
    st = 32'h8001_0001;
    rd(5'h18, r); check("R4 R6 rising on pins 0 16 31", r, st);
    wr(5'h18, 32'h0);
    rd(5'h18, r); check("R7 zero write keeps status", r, st);
    wr(5'h18, 32'h0001_0000);
    st = 32'h8000_0001;
    rd(5'h18, r); check("R7 one clears only that bit", r, st);
    check("R8 pending with mask 0 no irq", {31'h0, irqOut}, 32'h0);
    wr(5'h14, 32'h8000_0000);
    check("R9 irq with enabled pending bit", {31'h0, irqOut}, 32'h1);
    wr(5'h14, ~st);
    check("R9 irq low when mask misses pending", {31'h0, irqOut}, 32'h0);
    wr(5'h14, 32'h0);

    // R10: clear and new rising edge on pin 5 at the same edge
    pinIn = pinIn | 32'h20;
    settle(3);
    pinIn = pinIn & ~32'h20;
    settle(3);
    rd(5'h18, r); check("R6 pin5 pending before race", r, st | 32'h20);
    pinIn = pinIn | 32'h20;
    @(negedge clk);
    wr(5'h18, 32'h21);
    rd(5'h18, r); check("R10 event wins over clear", r, (st & ~32'h1) | 32'h20);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule